// File: doc/BRIEF.md
# Operand forwarding selection unit

This block decides, for the instruction in the execute stage of a five-stage pipeline, where each ALU operand comes from. It compares each source register number against the destination register and write-enable of the two older instructions held in the EX/MEM and MEM/WB pipeline registers. For each operand it drives a two-bit select and the chosen operand value.

A second, independent path serves the data-memory write port in the memory stage. A store that needs the register written by the load just ahead of it takes the loaded value from MEM/WB instead of the stale value it read in decode, so that pair runs without a bubble.

The block is purely combinational and has no clock or reset. Stall detection, the register file and the ALU sit outside it. The number of ALU operands, the data width and the register-index width are parameters. A parameter also selects whether register 0 is a constant zero that is never forwarded.

Top module: `fwd_unit`

## Requirements
- R1: When the EX/MEM stage has its write-enable set, its destination is nonzero and the destination equals an operand's source register, that operand's select is 2'b10 and the operand equals the EX/MEM result.
- R2: When only the MEM/WB stage matches an operand's source (write-enable set, nonzero destination), the select is 2'b01 and the operand equals the MEM/WB write-back value.
- R3: When both stages match the same source, the younger EX/MEM stage wins: the select is 2'b10 and the operand is the EX/MEM result.
- R4: With no match, the select is 2'b00 and the operand equals the register-file value for that operand. This includes the case where every input is zero.
- R5: A destination of register 0 never causes forwarding, on the ALU paths or the store path.
- R6: A stage whose write-enable is clear never causes forwarding, even when its destination equals the source.
- R7: When MEM/WB holds a load (load flag 1, write-enable 1, nonzero destination) whose destination equals the store-data register in the memory stage, the store-forward flag is 1 and the memory write data equals the MEM/WB value. Otherwise the flag is 0 and the write data equals the store's own data.
- R8: A MEM/WB producer with the load flag 0 never drives the store path, even when its register matches.
- R9: Each ALU operand is resolved independently. In one cycle, one operand may come from EX/MEM and the other from MEM/WB.
- R10: Store-data forwarding and ALU forwarding from the same MEM/WB load happen in the same cycle without affecting each other.
- R11: The select value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_reg | input | NUM_SRC x REG_AW | Source register number of each ALU operand in EX |
| ex_rf_val | input | NUM_SRC x XLEN | Register-file value read for each operand |
| em_wen | input | 1 | EX/MEM register-write enable |
| em_dst | input | REG_AW | EX/MEM destination register |
| em_val | input | XLEN | EX/MEM ALU result |
| mw_wen | input | 1 | MEM/WB register-write enable |
| mw_is_load | input | 1 | MEM/WB holds a load |
| mw_dst | input | REG_AW | MEM/WB destination register |
| mw_val | input | XLEN | MEM/WB write-back value |
| mem_st_reg | input | REG_AW | Store-data register of the instruction in MEM |
| mem_st_val | input | XLEN | Store data carried down the pipe |
| alu_sel | output | NUM_SRC x 2 | Select per operand: 00 register file, 10 EX/MEM, 01 MEM/WB |
| alu_opnd | output | NUM_SRC x XLEN | Chosen operand per ALU input |
| st_fwd | output | 1 | Store data taken from MEM/WB |
| st_wdata | output | XLEN | Data for the memory write port |

## Verification
Two functions can land in the same cycle: the ALU bypass and the store-data bypass, both fed by one load sitting in MEM/WB. The bench provokes this by placing a load in MEM/WB whose destination matches both an ALU source in EX and the store-data register in MEM. It expects the MEM/WB select on the ALU operand and the store-forward flag at the memory port together. A second pattern adds an EX/MEM match on the same source, so the ALU operand must switch to EX/MEM while the store path keeps the load value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } opnd_src_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic              wen,
   input  logic [REG_AW-1:0] dst,
   output logic              hit
);

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign hit = wen && (dst != '0) && (dst == src);
      end else begin : g_zero_plain
         assign hit = wen && (dst == src);
      end
   endgenerate

endmodule

// File: rtl/fwd_alu_sel.sv
module fwd_alu_sel
   import fwd_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [XLEN-1:0]   rf_val,
   input  logic              em_wen,
   input  logic [REG_AW-1:0] em_dst,
   input  logic [XLEN-1:0]   em_val,
   input  logic              mw_wen,
   input  logic [REG_AW-1:0] mw_dst,
   input  logic [XLEN-1:0]   mw_val,
   output logic [1:0]        sel,
   output logic [XLEN-1:0]   opnd
);

   logic      em_hit;
   logic      mw_hit;
   opnd_src_e pick;

   fwd_match #(.REG_AW(REG_AW), .ZERO_IS_CONST(ZERO_IS_CONST)) u_em_cmp (
      .src(src), .wen(em_wen), .dst(em_dst), .hit(em_hit)
   );

   fwd_match #(.REG_AW(REG_AW), .ZERO_IS_CONST(ZERO_IS_CONST)) u_mw_cmp (
      .src(src), .wen(mw_wen), .dst(mw_dst), .hit(mw_hit)
   );

   // younger producer first
   always_comb begin
      if (em_hit) begin
         pick = SRC_MEM;
      end else if (mw_hit) begin
         pick = SRC_WB;
      end else begin
         pick = SRC_RF;
      end
   end

   always_comb begin
      unique case (pick)
         SRC_MEM: opnd = em_val;
         SRC_WB:  opnd = mw_val;
         default: opnd = rf_val;
      endcase
   end

   assign sel = pick;

   always_comb begin
      AST_EM_NEEDS_MATCH: assert (sel != 2'b10 || (em_wen && em_dst == src)) else $error("EX/MEM select without matching writer"); // R1
      AST_EM_ZERO_BLOCKED: assert (!ZERO_IS_CONST || sel != 2'b10 || em_dst != '0) else $error("register 0 forwarded from EX/MEM"); // R5
      AST_WB_NEEDS_MATCH: assert (sel != 2'b01 || (mw_wen && mw_dst == src)) else $error("MEM/WB select without matching writer"); // R2
      AST_WB_YIELDS: assert (sel != 2'b01 || !(em_wen && em_dst == src && (!ZERO_IS_CONST || em_dst != '0))) else $error("older stage chosen over younger"); // R3
      AST_NO_WEN_NO_FWD: assert ((em_wen || mw_wen) || sel == 2'b00) else $error("forward with all write enables low"); // R6
      AST_RF_PASS: assert (sel != 2'b00 || opnd == rf_val) else $error("register-file operand altered"); // R4
      AST_SEL_LEGAL: assert (sel != 2'b11) else $error("illegal select code"); // R11
   end

endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
   parameter int XLEN          = 32,
   parameter int REG_AW        = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_AW-1:0] st_reg,
   input  logic [XLEN-1:0]   st_val,
   input  logic              mw_wen,
   input  logic              mw_is_load,
   input  logic [REG_AW-1:0] mw_dst,
   input  logic [XLEN-1:0]   mw_val,
   output logic              st_fwd,
   output logic [XLEN-1:0]   wdata
);

   logic load_wr;

   assign load_wr = mw_wen & mw_is_load;

   fwd_match #(.REG_AW(REG_AW), .ZERO_IS_CONST(ZERO_IS_CONST)) u_ld_cmp (
      .src(st_reg), .wen(load_wr), .dst(mw_dst), .hit(st_fwd)
   );

   assign wdata = st_fwd ? mw_val : st_val;

   always_comb begin
      AST_ST_LOAD_ONLY: assert (!st_fwd || (mw_is_load && mw_wen)) else $error("store forwarded from non-load"); // R8
      AST_ST_REG_MATCH: assert (!st_fwd || mw_dst == st_reg) else $error("store forwarded on register mismatch"); // R7
      AST_ST_ZERO_BLOCKED: assert (!ZERO_IS_CONST || !st_fwd || mw_dst != '0) else $error("register 0 forwarded to store"); // R5
      AST_ST_PASS: assert (st_fwd || wdata == st_val) else $error("store data altered without forward"); // R7
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int REG_AW        = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src_reg,
   input  logic [NUM_SRC-1:0][XLEN-1:0]   ex_rf_val,
   input  logic                           em_wen,
   input  logic [REG_AW-1:0]              em_dst,
   input  logic [XLEN-1:0]                em_val,
   input  logic                           mw_wen,
   input  logic                           mw_is_load,
   input  logic [REG_AW-1:0]              mw_dst,
   input  logic [XLEN-1:0]                mw_val,
   input  logic [REG_AW-1:0]              mem_st_reg,
   input  logic [XLEN-1:0]                mem_st_val,
   output logic [NUM_SRC-1:0][1:0]        alu_sel,
   output logic [NUM_SRC-1:0][XLEN-1:0]   alu_opnd,
   output logic                           st_fwd,
   output logic [XLEN-1:0]                st_wdata
);

   localparam int NUM_REGS = 1 << REG_AW;

   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("XLEN must be at least 1");
      end
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_nsrc
         $error("NUM_SRC must lie in 1..4");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("register file too small");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_opnd
         fwd_alu_sel #(
            .XLEN(XLEN), .REG_AW(REG_AW), .ZERO_IS_CONST(ZERO_IS_CONST)
         ) u_sel (
            .src    (ex_src_reg[gi]),
            .rf_val (ex_rf_val[gi]),
            .em_wen (em_wen),
            .em_dst (em_dst),
            .em_val (em_val),
            .mw_wen (mw_wen),
            .mw_dst (mw_dst),
            .mw_val (mw_val),
            .sel    (alu_sel[gi]),
            .opnd   (alu_opnd[gi])
         );
      end
   endgenerate

   fwd_store_sel #(
      .XLEN(XLEN), .REG_AW(REG_AW), .ZERO_IS_CONST(ZERO_IS_CONST)
   ) u_store (
      .st_reg     (mem_st_reg),
      .st_val     (mem_st_val),
      .mw_wen     (mw_wen),
      .mw_is_load (mw_is_load),
      .mw_dst     (mw_dst),
      .mw_val     (mw_val),
      .st_fwd     (st_fwd),
      .wdata      (st_wdata)
   );

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

   localparam int XLEN = 32;
   localparam int AW   = 5;
   localparam int NS   = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;

   logic [NS-1:0][AW-1:0]   ex_src_reg;
   logic [NS-1:0][XLEN-1:0] ex_rf_val;
   logic                    em_wen;
   logic [AW-1:0]           em_dst;
   logic [XLEN-1:0]         em_val;
   logic                    mw_wen;
   logic                    mw_is_load;
   logic [AW-1:0]           mw_dst;
   logic [XLEN-1:0]         mw_val;
   logic [AW-1:0]           mem_st_reg;
   logic [XLEN-1:0]         mem_st_val;
   logic [NS-1:0][1:0]      alu_sel;
   logic [NS-1:0][XLEN-1:0] alu_opnd;
   logic                    st_fwd;
   logic [XLEN-1:0]         st_wdata;

   fwd_unit #(.XLEN(XLEN), .REG_AW(AW), .NUM_SRC(NS), .ZERO_IS_CONST(1'b1)) dut (
      .ex_src_reg (ex_src_reg),
      .ex_rf_val  (ex_rf_val),
      .em_wen     (em_wen),
      .em_dst     (em_dst),
      .em_val     (em_val),
      .mw_wen     (mw_wen),
      .mw_is_load (mw_is_load),
      .mw_dst     (mw_dst),
      .mw_val     (mw_val),
      .mem_st_reg (mem_st_reg),
      .mem_st_val (mem_st_val),
      .alu_sel    (alu_sel),
      .alu_opnd   (alu_opnd),
      .st_fwd     (st_fwd),
      .st_wdata   (st_wdata)
   );

   typedef struct {
      string           tag;
      logic [1:0]      sel0;
      logic [1:0]      sel1;
      logic [XLEN-1:0] op0;
      logic [XLEN-1:0] op1;
      logic            sf;
      logic [XLEN-1:0] sw;
   } exp_t;

   exp_t sb_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   function automatic logic [1:0] ref_sel(input logic [AW-1:0] src);
      if (em_wen && em_dst != '0 && em_dst == src) return 2'b10;
      if (mw_wen && mw_dst != '0 && mw_dst == src) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [XLEN-1:0] ref_val(input logic [1:0] s, input logic [XLEN-1:0] rf);
      if (s == 2'b10) return em_val;
      if (s == 2'b01) return mw_val;
      return rf;
   endfunction

   task automatic check(input string tag, input string fld,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
      end
   endtask

   // driver: apply one pattern per cycle and push the expectation
   task automatic apply(input string tag,
                        input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                        input logic [XLEN-1:0] r0, input logic [XLEN-1:0] r1,
                        input logic ew, input logic [AW-1:0] ed, input logic [XLEN-1:0] ev,
                        input logic mw, input logic ld, input logic [AW-1:0] md,
                        input logic [XLEN-1:0] mv,
                        input logic [AW-1:0] sr, input logic [XLEN-1:0] sv);
      exp_t e;
      @(posedge clk);
      #1;
      ex_src_reg[0] = s0;  ex_src_reg[1] = s1;
      ex_rf_val[0]  = r0;  ex_rf_val[1]  = r1;
      em_wen = ew;  em_dst = ed;  em_val = ev;
      mw_wen = mw;  mw_is_load = ld;  mw_dst = md;  mw_val = mv;
      mem_st_reg = sr;  mem_st_val = sv;
      e.tag  = tag;
      e.sel0 = ref_sel(s0);
      e.sel1 = ref_sel(s1);
      e.op0  = ref_val(e.sel0, r0);
      e.op1  = ref_val(e.sel1, r1);
      e.sf   = mw && ld && md != '0 && md == sr;
      e.sw   = e.sf ? mv : sv;
      sb_q.push_back(e);
   endtask

   // monitor: compare at the falling edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, "sel0",   XLEN'(alu_sel[0]), XLEN'(e.sel0));
            check(e.tag, "sel1",   XLEN'(alu_sel[1]), XLEN'(e.sel1));
            check(e.tag, "opnd0",  alu_opnd[0], e.op0);
            check(e.tag, "opnd1",  alu_opnd[1], e.op1);
            check(e.tag, "st_fwd", XLEN'(st_fwd), XLEN'(e.sf));
            check(e.tag, "st_wd",  st_wdata, e.sw);
         end
      end
   end

   initial begin
      #4_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      ex_src_reg = '0;  ex_rf_val = '0;
      em_wen = 1'b0;  em_dst = '0;  em_val = '0;
      mw_wen = 1'b0;  mw_is_load = 1'b0;  mw_dst = '0;  mw_val = '0;
      mem_st_reg = '0;  mem_st_val = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R4: idle pattern, all controls zero
      apply("R4 idle", 5'd0, 5'd0, 32'h0, 32'h0,
            1'b0, 5'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 32'h0);
      // R4: no match with live writers on other registers
      apply("R4 no match", 5'd3, 5'd4, 32'h1111_0003, 32'h1111_0004,
            1'b1, 5'd7, 32'hAAAA_0007, 1'b1, 1'b0, 5'd8, 32'hBBBB_0008, 5'd9, 32'hCCCC_0009);
      // R1: EX/MEM hit on operand 0
      apply("R1 em hit", 5'd5, 5'd6, 32'h1111_0005, 32'h1111_0006,
            1'b1, 5'd5, 32'hAAAA_0005, 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 32'h0);
      // R2: MEM/WB hit on operand 1
      apply("R2 wb hit", 5'd5, 5'd6, 32'h1111_0005, 32'h1111_0006,
            1'b0, 5'd6, 32'hAAAA_0006, 1'b1, 1'b0, 5'd6, 32'hBBBB_0006, 5'd0, 32'h0);
      // R3: both stages match operand 0
      apply("R3 both hit", 5'd10, 5'd10, 32'h1111_000A, 32'h2222_000A,
            1'b1, 5'd10, 32'hAAAA_000A, 1'b1, 1'b0, 5'd10, 32'hBBBB_000A, 5'd0, 32'h0);
      // R5: register 0 destination on both stages
      apply("R5 zero dst", 5'd0, 5'd0, 32'h1111_0000, 32'h2222_0000,
            1'b1, 5'd0, 32'hAAAA_0000, 1'b1, 1'b1, 5'd0, 32'hBBBB_0000, 5'd0, 32'hCCCC_0000);
      // R6: matching registers with write enables low
      apply("R6 wen low", 5'd12, 5'd13, 32'h1111_000C, 32'h1111_000D,
            1'b0, 5'd12, 32'hAAAA_000C, 1'b0, 1'b1, 5'd13, 32'hBBBB_000D, 5'd13, 32'hCCCC_000D);
      // R7: load then store of same register
      apply("R7 store fwd", 5'd1, 5'd2, 32'h1111_0001, 32'h1111_0002,
            1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 5'd20, 32'hBBBB_0014, 5'd20, 32'hCCCC_0014);
      // R7: load to another register leaves store data alone
      apply("R7 store miss", 5'd1, 5'd2, 32'h1111_0001, 32'h1111_0002,
            1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 5'd21, 32'hBBBB_0015, 5'd20, 32'hCCCC_0014);
      // R8: non-load producer matching the store register
      apply("R8 non-load", 5'd1, 5'd2, 32'h1111_0001, 32'h1111_0002,
            1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 5'd20, 32'hBBBB_0014, 5'd20, 32'hCCCC_0014);
      // R9: operand 0 from EX/MEM, operand 1 from MEM/WB
      apply("R9 split", 5'd14, 5'd15, 32'h1111_000E, 32'h1111_000F,
            1'b1, 5'd14, 32'hAAAA_000E, 1'b1, 1'b0, 5'd15, 32'hBBBB_000F, 5'd0, 32'h0);
      // R10: one load feeds ALU operand and store in the same cycle
      apply("R10 dual", 5'd17, 5'd2, 32'h1111_0011, 32'h1111_0002,
            1'b0, 5'd0, 32'h0, 1'b1, 1'b1, 5'd17, 32'hBBBB_0011, 5'd17, 32'hCCCC_0011);
      // R10 with R3: EX/MEM also matches, store path keeps load value
      apply("R10 dual em", 5'd17, 5'd17, 32'h1111_0011, 32'h2222_0011,
            1'b1, 5'd17, 32'hAAAA_0011, 1'b1, 1'b1, 5'd17, 32'hBBBB_0011, 5'd17, 32'hCCCC_0011);
      // R11 with R1..R9: mixed patterns over a small register range
      for (int i = 0; i < 60; i++) begin
         apply("R11 mixed",
               5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               $urandom(), $urandom(),
               1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), $urandom(),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               5'($urandom_range(0, 3)), $urandom(),
               5'($urandom_range(0, 3)), $urandom());
      end

      wait (sb_q.size() == 0);
      @(negedge clk);
      #1;
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule